// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Unit

This unit sits between a processor's single interrupt input and a set of `N_DEV` devices that share that request line. Each device presents a request bit and an enable bit. The processor sees the OR of all enabled requests. When the processor answers with an acknowledge pulse, the unit passes that pulse down a chain of gates. A device stops the acknowledge from going further when its own request is enabled and pending. So exactly one requesting device receives the grant, and only that device drives the shared data bus.

The granted device's number appears on a vector output with a valid flag, one cycle after the acknowledge is sampled. A per-device one-hot acknowledge bus is driven at the same time. In fixed mode (`ROTATE = 0`), device 0 is at the head of the chain and has the highest priority. In rotating mode (`ROTATE = 1`), the chain starts at the device just after the one granted last and wraps around. This gives devices far from the head a fair share of service. A value of `N_DEV` outside 2 to 16 stops elaboration.

A small state machine drives the outputs:

- `ST_IDLE` means no acknowledge was seen in the previous cycle.
- `ST_GRANT` means the previous cycle's acknowledge found a pending device.
- `ST_MISS` means the previous cycle's acknowledge found no pending device.

From every state, the next state is chosen the same way:

- acknowledge high with a device pending goes to `ST_GRANT`;
- acknowledge high with nothing pending goes to `ST_MISS`;
- acknowledge low goes to `ST_IDLE`.

Top module: `irq_daisy_chain`

## Requirements
- R1: `cpu_irq` equals the OR over all devices of `dev_req & dev_en`, in the same cycle with no register.
- R2: When `cpu_iack` is sampled high at a clock edge and at least one device has an enabled request, then after that edge `vec_valid` is 1 for that cycle, and `dev_ack` has exactly one bit set, at position `vec_idx`.
- R3: In fixed mode, the granted device is the lowest-numbered device whose request and enable are both 1.
- R4: A device with `dev_req = 1` and `dev_en = 0` is never granted and does not stop the acknowledge from reaching later devices.
- R5: When `cpu_iack` is sampled high and no device has an enabled request, then in the next cycle `vec_valid` is 0, `dev_ack` is all zero and `vec_idx` is 0.
- R6: In rotating mode, the search starts at the device one above the last granted device, counts upward, and wraps from `N_DEV-1` to 0. The first device found with an enabled request is granted.
- R7: Reset sets the last-granted pointer to `N_DEV-1`. As a result, the first rotating search after reset starts at device 0.
- R8: The last-granted pointer changes only on an acknowledge that produces a grant. An acknowledge that finds nothing pending leaves the next rotating search unchanged.
- R9: When `cpu_iack` was low at the previous clock edge, and also during reset, `vec_valid` is 0 and `dev_ack` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_DEV | Per-device interrupt request |
| dev_en | input | N_DEV | Per-device request enable |
| cpu_iack | input | 1 | Acknowledge from the processor, sampled at the clock edge |
| cpu_irq | output | 1 | Combined interrupt request to the processor |
| dev_ack | output | N_DEV | One-hot acknowledge to the granted device |
| vec_idx | output | $clog2(N_DEV) | Number of the granted device |
| vec_valid | output | 1 | Grant present on `vec_idx` and `dev_ack` |

## Verification
The bench builds two copies of the unit side by side, driven from shared request and enable vectors.

The first copy is a fixed-priority chain of 4 devices. It brings within reach lowest-index selection, disabled requests being skipped, and acknowledges that find no request.

The second copy is a rotating chain of 5 devices. Because 5 is not a power of two, the wrap from device 4 back to device 0 falls inside a wider index field. This lets the bench test the wrap, the start at device 0 after reset, and that the pointer holds across an acknowledge with no grant.

// File: rtl/irq_dc_pkg.sv
package irq_dc_pkg;

    // Output state of the acknowledge unit
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_MISS  = 2'd2
    } ack_state_e;

endpackage

// File: rtl/irq_rr_pointer.sv
// Holds the last granted device and derives where the chain starts.
module irq_rr_pointer #(
    parameter int N_DEV  = 8,
    parameter bit ROTATE = 1'b0,
    parameter int IW     = $clog2(N_DEV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [IW-1:0] upd_idx,
    output logic [IW-1:0] start
);

    localparam logic [IW-1:0] LAST_DEV = IW'(N_DEV - 1);

    logic [IW-1:0] last_q;

    // Reset to the final device, so the first rotating search begins at 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= LAST_DEV;
        end else if (upd) begin
            last_q <= upd_idx;
        end
    end

    generate
        if (ROTATE) begin : g_rotate
            assign start = (last_q == LAST_DEV) ? '0 : last_q + IW'(1);
        end else begin : g_fixed
            assign start = '0;
        end
    endgenerate

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(last_q)); // R8

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        last_q <= LAST_DEV); // R6

endmodule

// File: rtl/irq_chain_resolve.sv
// Acknowledge ripple. Visiting order is start, start+1, ... modulo N_DEV.
module irq_chain_resolve #(
    parameter int N_DEV = 8,
    parameter int IW    = $clog2(N_DEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack,
    input  logic [N_DEV-1:0] pend,
    input  logic [IW-1:0]    start,
    output logic [N_DEV-1:0] grant,
    output logic [IW-1:0]    gidx,
    output logic             hit
);

    localparam logic [IW:0] N_EXT = (IW+1)'(N_DEV);

    always_comb begin
        logic          pass_on;
        logic [IW:0]   pos;
        logic [IW-1:0] dev;
        pass_on = iack;
        grant   = '0;
        gidx    = '0;
        hit     = 1'b0;
        for (int k = 0; k < N_DEV; k++) begin
            pos = {1'b0, start} + (IW+1)'(k);
            if (pos >= N_EXT) begin
                pos = pos - N_EXT;
            end
            dev = pos[IW-1:0];
            // The acknowledge stops at the first device with a pending request
            if (pass_on && pend[dev]) begin
                grant[dev] = 1'b1;
                gidx       = dev;
                hit        = 1'b1;
            end
            pass_on = pass_on & ~pend[dev];
        end
    end

    AST_CHAIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2

    AST_CHAIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend) == '0); // R4

    AST_CHAIN_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !iack |-> grant == '0); // R9

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
    import irq_dc_pkg::*;
#(
    parameter int N_DEV  = 8,
    parameter bit ROTATE = 1'b0,
    localparam int IW    = $clog2(N_DEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] dev_req,
    input  logic [N_DEV-1:0] dev_en,
    input  logic             cpu_iack,
    output logic             cpu_irq,
    output logic [N_DEV-1:0] dev_ack,
    output logic [IW-1:0]    vec_idx,
    output logic             vec_valid
);

    generate
        if (N_DEV < 2 || N_DEV > 16) begin : g_bad_size
            $error("irq_daisy_chain: N_DEV must lie in 2..16");
        end
    endgenerate

    ack_state_e       state_q, state_d;
    logic [N_DEV-1:0] pend;
    logic [N_DEV-1:0] grant;
    logic [IW-1:0]    gidx;
    logic [IW-1:0]    start;
    logic             hit;
    logic [N_DEV-1:0] ack_q;
    logic [IW-1:0]    idx_q;

    // A disabled request is invisible to both the processor and the chain
    assign pend    = dev_req & dev_en;
    assign cpu_irq = |pend;

    irq_rr_pointer #(.N_DEV(N_DEV), .ROTATE(ROTATE), .IW(IW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (cpu_iack & hit),
        .upd_idx (gidx),
        .start   (start)
    );

    irq_chain_resolve #(.N_DEV(N_DEV), .IW(IW)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .iack  (cpu_iack),
        .pend  (pend),
        .start (start),
        .grant (grant),
        .gidx  (gidx),
        .hit   (hit)
    );

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_MISS: begin
                if (cpu_iack) begin
                    state_d = hit ? ST_GRANT : ST_MISS;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (cpu_iack) begin
                ack_q <= grant;
                idx_q <= gidx;
            end
        end
    end

    // Outputs from state
    always_comb begin
        dev_ack   = '0;
        vec_idx   = '0;
        vec_valid = 1'b0;
        unique case (state_q)
            ST_GRANT: begin
                dev_ack   = ack_q;
                vec_idx   = idx_q;
                vec_valid = 1'b1;
            end
            ST_IDLE, ST_MISS: begin
                vec_valid = 1'b0;
            end
            default: vec_valid = 1'b0;
        endcase
    end

    AST_GRANT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_iack && cpu_irq) |=> vec_valid); // R2

    AST_ACK_MATCHES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> dev_ack == (N_DEV'(1) << vec_idx)); // R2

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_iack && !cpu_irq) |=> (!vec_valid && dev_ack == '0 && vec_idx == '0)); // R5

    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_iack |=> (!vec_valid && dev_ack == '0)); // R9

endmodule

// File: tb/irq_daisy_chain_bench.sv
module irq_daisy_chain_bench;

    typedef struct {
        int    due;
        bit    rot;
        bit    vld;
        int    idx;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req = '0;
    logic [4:0] en = '0;
    logic       iack = 1'b0;

    logic       f_irq, f_vld;
    logic [3:0] f_ack;
    logic [1:0] f_idx;
    logic       r_irq, r_vld;
    logic [4:0] r_ack;
    logic [2:0] r_idx;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   r_last = 4;
    exp_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_daisy_chain #(.N_DEV(4), .ROTATE(1'b0)) u_irq_daisy_chain (
        .clk(clk), .rst_n(rst_n), .dev_req(req[3:0]), .dev_en(en[3:0]),
        .cpu_iack(iack), .cpu_irq(f_irq), .dev_ack(f_ack),
        .vec_idx(f_idx), .vec_valid(f_vld)
    );

    irq_daisy_chain #(.N_DEV(5), .ROTATE(1'b1)) u_irq_daisy_chain_rot (
        .clk(clk), .rst_n(rst_n), .dev_req(req), .dev_en(en),
        .cpu_iack(iack), .cpu_irq(r_irq), .dev_ack(r_ack),
        .vec_idx(r_idx), .vec_valid(r_vld)
    );

    task automatic chk(input string tag, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    // Driver: one acknowledge, expected results pushed to the scoreboard
    task automatic do_ack(input logic [4:0] rq, input logic [4:0] ev,
                          input string tf, input string tr);
        logic [4:0] p;
        exp_t       e;
        int         fi, ri;
        @(negedge clk);
        req = rq;
        en = ev;
        iack = 1'b1;
        p = rq & ev;
        #1;
        chk("R1 fixed irq", f_irq == |p[3:0], int'(f_irq), int'(|p[3:0]));
        chk("R1 rot irq", r_irq == |p, int'(r_irq), int'(|p));
        fi = -1;
        for (int i = 3; i >= 0; i--) if (p[i]) fi = i;
        ri = -1;
        for (int k = 0; k < 5; k++) begin
            int d = (r_last + 1 + k) % 5;
            if (ri < 0 && p[d]) ri = d;
        end
        if (ri >= 0) r_last = ri;
        e.due = cyc + 1; e.rot = 1'b0; e.vld = (fi >= 0); e.idx = (fi >= 0) ? fi : 0; e.tag = tf;
        exp_q.push_back(e);
        e.rot = 1'b1; e.vld = (ri >= 0); e.idx = (ri >= 0) ? ri : 0; e.tag = tr;
        exp_q.push_back(e);
        @(negedge clk);
        iack = 1'b0;
    endtask

    // Monitor: compare at the negedge after the sampling edge
    always @(negedge clk) begin
        bit   f_seen, r_seen;
        exp_t e;
        f_seen = 1'b0;
        r_seen = 1'b0;
        if (rst_n) begin
            while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                e = exp_q.pop_front();
                if (!e.rot) begin
                    f_seen = 1'b1;
                    chk({e.tag, " fixed valid"}, f_vld == e.vld, int'(f_vld), int'(e.vld));
                    chk({e.tag, " fixed idx"}, int'(f_idx) == e.idx, int'(f_idx), e.idx);
                    chk({e.tag, " fixed ack R2"}, f_ack == (e.vld ? (4'd1 << e.idx) : 4'd0),
                        int'(f_ack), e.vld ? (1 << e.idx) : 0);
                end else begin
                    r_seen = 1'b1;
                    chk({e.tag, " rot valid"}, r_vld == e.vld, int'(r_vld), int'(e.vld));
                    chk({e.tag, " rot idx"}, int'(r_idx) == e.idx, int'(r_idx), e.idx);
                    chk({e.tag, " rot ack R2"}, r_ack == (e.vld ? (5'd1 << e.idx) : 5'd0),
                        int'(r_ack), e.vld ? (1 << e.idx) : 0);
                end
            end
            if (!f_seen) chk("R9 fixed idle", !f_vld && f_ack == '0, int'(f_vld), 0);
            if (!r_seen) chk("R9 rot idle", !r_vld && r_ack == '0, int'(r_vld), 0);
        end
    end

    initial begin
        logic [4:0] lf;
        repeat (3) @(negedge clk);
        chk("R9 reset fixed", !f_vld && f_ack == '0, int'(f_vld), 0);
        chk("R9 reset rot", !r_vld && r_ack == '0, int'(r_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: nothing pending at all, then requests that are all disabled
        do_ack(5'b00000, 5'b11111, "R5 empty", "R5 empty");
        do_ack(5'b11111, 5'b00000, "R4 R5 all disabled", "R4 R5 all disabled");
        // R7: first rotating grant searches from device 0 -> 1; fixed R3 -> 1
        do_ack(5'b01010, 5'b11111, "R3", "R7");
        // R6: rotating now starts at 2 -> 3; fixed stays 1
        do_ack(5'b01010, 5'b11111, "R3", "R6");
        // R4: device 0 disabled, 1 and 2 enabled; rot start 4 wraps to 1
        do_ack(5'b00111, 5'b00110, "R4", "R6 wrap");
        // R8: miss keeps pointer at 1; next full request goes to 2
        do_ack(5'b10101, 5'b01010, "R5", "R8 miss");
        do_ack(5'b11111, 5'b11111, "R3", "R8 hold");
        // R6: only device 4 pending from start 3 on rotating; fixed sees none
        do_ack(5'b10000, 5'b11111, "R5 fixed none", "R6");
        // R6: pointer at 4, start wraps to 0
        do_ack(5'b00001, 5'b11111, "R3", "R6 wrap0");

        // R1 without acknowledge, R9 idle checked by monitor
        @(negedge clk);
        req = 5'b00100; en = 5'b00100;
        #1;
        chk("R1 no ack fixed", f_irq == 1'b1, int'(f_irq), 1);
        en = 5'b00000;
        #1;
        chk("R1 masked fixed", f_irq == 1'b0, int'(f_irq), 0);
        chk("R1 masked rot", r_irq == 1'b0, int'(r_irq), 0);

        // Sweep of mixed patterns
        lf = 5'b10110;
        for (int n = 0; n < 24; n++) begin
            lf = {lf[3:0], lf[4] ^ lf[2]};
            do_ack(lf, ~{lf[0], lf[4:1]} | 5'b10001, "R3 sweep", "R6 sweep");
        end
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule